// File: doc/BRIEF.md
# E1 Transmit Input Mode Controller

This block sits in front of the line driver of one E1 transmit channel. It runs on a fast system clock, a fixed multiple of the 2.048 Mbit/s line rate (16x by default). It watches the channel's incoming transmit clock to decide how the channel should be driven. While that clock toggles, the channel works in clocked mode. The positive and negative data inputs hold NRZ levels and are sampled on each falling transmit-clock edge. Every sampled one becomes a single mark pulse, half a bit period long, on the matching polarity output.

When the transmit clock stops, a watchdog declares it idle after four bit periods. The static level it rests at then picks the mode. A high level selects clockless pass-through: the data inputs carry RZ pulses, and these are forwarded with their width unchanged. A low level shuts the driver off and deasserts the output enable, while the data inputs may keep toggling. A global enable input, low out of reset, gates every channel. The downstream analog stage uses the two polarity enables and the output-enable flag to form the line pulse.

All asynchronous inputs pass through a multi-flop synchronizer before any edge or level is used. A bit in which both data inputs are sampled high produces no mark and sets a sticky error flag.

Top module: `e1tx_mode_ctrl`

## Requirements
- R1: While reset is held and right after it, drive_en, mark_p, mark_n and both_err are 0 and mode is 2'b00 (shut-off).
- R2: While the transmit clock toggles with gaps shorter than 4 bit periods (64 system clocks), mode reads 2'b10 (clocked NRZ). The value 2'b11 never appears.
- R3: In clocked mode, each falling transmit-clock edge samples data_p and data_n. A sampled one on data_p alone yields exactly one mark_p pulse, and a sampled one on data_n alone yields exactly one mark_n pulse, in bit order. A sampled zero on both yields nothing.
- R4: Each clocked-mode mark pulse lasts exactly OVERSAMPLE/2 system clocks (8 by default).
- R5: A clocked bit with both data inputs sampled high produces no mark and sets both_err, which stays 1 until reset. mark_p and mark_n are never high together.
- R6: After the transmit clock has rested high for 4 bit periods, mode reads 2'b01 (clockless RZ). Each data_p (data_n) pulse is then reproduced on mark_p (mark_n) with the same width in system clocks. Overlapping high levels on both inputs drive neither output.
- R7: After the transmit clock has rested low for 4 bit periods, mode reads 2'b00 and drive_en is 0. Activity on the data inputs produces no mark.
- R8: With tx_enable low, drive_en, mark_p and mark_n stay 0 in every mode. With tx_enable high and a mode other than shut-off, drive_en is 1.
- R9: When the transmit clock stops, mode stays at 2'b10 for the first 40 system clocks of the idle interval and changes only once the 64-clock limit has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, OVERSAMPLE times the line rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_enable | input | 1 | Global transmit enable, asynchronous |
| line_clk | input | 1 | Channel transmit clock from terminal equipment, asynchronous |
| data_p | input | 1 | Positive-mark data (NRZ when clocked, RZ when clockless) |
| data_n | input | 1 | Negative-mark data (NRZ when clocked, RZ when clockless) |
| mark_p | output | 1 | Positive-polarity pulse enable to the driver |
| mark_n | output | 1 | Negative-polarity pulse enable to the driver |
| drive_en | output | 1 | Output enable; 0 tri-states the driver |
| mode | output | 2 | Selected mode: 00 shut-off, 01 clockless, 10 clocked |
| both_err | output | 1 | Sticky flag: both data inputs sampled high in one clocked bit |

## Verification
The bench builds the block with its defaults: 16 system clocks per bit, a 4-bit idle limit and two synchronizer stages. With these values the idle limit is 64 clocks and a clocked mark is 8 clocks long, so both can be probed on either side within a short run. In clocked mode the bench runs every 4-bit word of positive and negative bit pairs, which covers each ordering of polarity, zero and the both-high case. In clockless mode it sweeps input pulse widths from 3 to 12 clocks. The shut-off and global-enable cases are driven with data still active.

// File: rtl/e1tx_pkg.sv
package e1tx_pkg;
   typedef enum logic [1:0] {
      TXM_OFF = 2'b00,
      TXM_RZ  = 2'b01,
      TXM_NRZ = 2'b10
   } txm_e;
endpackage

// File: rtl/e1tx_sync.sv
module e1tx_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/e1tx_activity.sv
module e1tx_activity
   import e1tx_pkg::*;
#(
   parameter int IDLE_LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lclk_s,
   output txm_e mode,
   output logic fall
);
   localparam int CW = $clog2(IDLE_LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

   logic          prev_q;
   logic [CW-1:0] idle_q;
   logic          toggled;

   assign toggled = prev_q ^ lclk_s;
   assign fall    = prev_q & ~lclk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         idle_q <= LIM;
      end else begin
         prev_q <= lclk_s;
         if (toggled)         idle_q <= '0;
         else if (idle_q < LIM) idle_q <= idle_q + 1'b1;
      end
   end

   always_comb begin
      if (idle_q < LIM)  mode = TXM_NRZ;
      else if (lclk_s)   mode = TXM_RZ;
      else               mode = TXM_OFF;
   end
endmodule

// File: rtl/e1tx_nrz_marker.sv
module e1tx_nrz_marker #(
   parameter int MARK_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fall,
   input  logic dp,
   input  logic dn,
   output logic mp,
   output logic mn,
   output logic err
);
   localparam int MW = $clog2(MARK_LEN + 1);
   localparam logic [MW-1:0] LEN = MW'(MARK_LEN);

   logic [MW-1:0] left_q;
   logic          pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         pos_q  <= 1'b0;
         err    <= 1'b0;
      end else if (fall) begin
         if (dp && dn) begin
            left_q <= '0;
            err    <= 1'b1;
         end else if (dp || dn) begin
            left_q <= LEN;
            pos_q  <= dp;
         end else begin
            left_q <= '0;
         end
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign mp = (left_q != '0) &&  pos_q;
   assign mn = (left_q != '0) && !pos_q;
endmodule

// File: rtl/e1tx_mode_ctrl.sv
module e1tx_mode_ctrl
   import e1tx_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int IDLE_BITS   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_enable,
   input  logic       line_clk,
   input  logic       data_p,
   input  logic       data_n,
   output logic       mark_p,
   output logic       mark_n,
   output logic       drive_en,
   output logic [1:0] mode,
   output logic       both_err
);
   localparam int MARK_LEN   = OVERSAMPLE / 2;
   localparam int IDLE_LIMIT = IDLE_BITS * OVERSAMPLE;

   if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
      $error("OVERSAMPLE must be even and at least 4");
   end
   if (IDLE_BITS < 2) begin : g_bad_idle
      $error("IDLE_BITS must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [3:0] raw, synced;
   logic       en_s, lclk_s, dp_s, dn_s;
   txm_e       cur_mode;
   logic       fall;
   logic       nrz_p, nrz_n;
   logic       nxt_p, nxt_n, nxt_en;

   assign raw = {tx_enable, line_clk, data_p, data_n};
   assign {en_s, lclk_s, dp_s, dn_s} = synced;

   e1tx_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
   );

   e1tx_activity #(.IDLE_LIMIT(IDLE_LIMIT)) u_act (
      .clk(clk), .rst_n(rst_n), .lclk_s(lclk_s), .mode(cur_mode), .fall(fall)
   );

   e1tx_nrz_marker #(.MARK_LEN(MARK_LEN)) u_mark (
      .clk(clk), .rst_n(rst_n), .fall(fall), .dp(dp_s), .dn(dn_s),
      .mp(nrz_p), .mn(nrz_n), .err(both_err)
   );

   always_comb begin
      nxt_p = 1'b0;
      nxt_n = 1'b0;
      unique case (cur_mode)
         TXM_NRZ: begin
            nxt_p = nrz_p;
            nxt_n = nrz_n;
         end
         TXM_RZ: begin
            nxt_p = dp_s & ~dn_s;
            nxt_n = dn_s & ~dp_s;
         end
         default: ;
      endcase
      nxt_en = en_s && (cur_mode != TXM_OFF);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mark_p   <= 1'b0;
         mark_n   <= 1'b0;
         drive_en <= 1'b0;
      end else begin
         mark_p   <= nxt_p & nxt_en;
         mark_n   <= nxt_n & nxt_en;
         drive_en <= nxt_en;
      end
   end

   assign mode = cur_mode;
endmodule

// File: rtl/e1tx_mode_ctrl_chk.sv
module e1tx_mode_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_enable,
   input logic       mark_p,
   input logic       mark_n,
   input logic       drive_en,
   input logic [1:0] mode,
   input logic       both_err
);
   p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mark_p && mark_n));

   p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      both_err |=> both_err);

   p_legal_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'b11);

   p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> !drive_en);

   p_mark_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_p || mark_n) |-> drive_en);

   p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_enable && !$past(tx_enable) && !$past(tx_enable, 2) && !$past(tx_enable, 3))
      |-> !drive_en);
endmodule

bind e1tx_mode_ctrl e1tx_mode_ctrl_chk u_chk (.*);

// File: tb/e1tx_mode_ctrl_tb.sv
module e1tx_mode_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_enable = 1'b0, line_clk = 1'b0, data_p = 1'b0, data_n = 1'b0;
   logic mark_p, mark_n, drive_en, both_err;
   logic [1:0] mode;

   int checks = 0, errors = 0, cycles = 0;
   bit done = 1'b0;

   int lp [0:2047];
   int lw [0:2047];
   int nlog = 0;
   int ep [0:2047];
   int ew [0:2047];
   int ne = 0;
   int runp = 0, runn = 0;

   always #5 clk = ~clk;

   e1tx_mode_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .line_clk(line_clk),
      .data_p(data_p), .data_n(data_n), .mark_p(mark_p), .mark_n(mark_n),
      .drive_en(drive_en), .mode(mode), .both_err(both_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (mark_p) runp++;
      else if (runp > 0) begin
         if (nlog < 2048) begin lp[nlog] = 1; lw[nlog] = runp; end
         nlog++; runp = 0;
      end
      if (mark_n) runn++;
      else if (runn > 0) begin
         if (nlog < 2048) begin lp[nlog] = 0; lw[nlog] = runn; end
         nlog++; runn = 0;
      end
   end

   always @(negedge clk) begin
      if (cycles > 200000 && !done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_log();
      nlog = 0; ne = 0;
   endtask

   task automatic expect_mark(input int pol, input int w);
      ep[ne] = pol; ew[ne] = w; ne++;
   endtask

   task automatic send_bit(input bit p, input bit n);
      @(negedge clk);
      line_clk = 1'b1; data_p = p; data_n = n;
      wait_n(8);
      line_clk = 1'b0;
      wait_n(7);
   endtask

   task automatic send_clocked(input bit p, input bit n);
      send_bit(p, n);
      if (p ^ n) expect_mark(p ? 1 : 0, 8);
   endtask

   task automatic compare_log(input string req);
      check(nlog == ne, {req, " mark count"}, nlog, ne);
      for (int i = 0; i < ne && i < nlog; i++) begin
         check(lp[i] == ep[i], {req, " polarity"}, lp[i], ep[i]);
         check(lw[i] == ew[i], {req, " width (R4 in clocked mode)"}, lw[i], ew[i]);
      end
   endtask

   task automatic rz_pulse(input bit p, input bit n, input int w);
      @(negedge clk);
      data_p = p; data_n = n;
      wait_n(w);
      data_p = 1'b0; data_n = 1'b0;
      wait_n(10);
      if (p ^ n) expect_mark(p ? 1 : 0, w);
   endtask

   initial begin
      // R1: reset state
      wait_n(5);
      check(drive_en == 1'b0 && mark_p == 1'b0 && mark_n == 1'b0, "R1 outputs in reset",
            int'({drive_en, mark_p, mark_n}), 0);
      check(both_err == 1'b0, "R1 both_err in reset", both_err, 0);
      check(mode == 2'b00, "R1 mode in reset", mode, 0);
      rst_n = 1'b1;
      tx_enable = 1'b1;

      // R2: clocked mode detected
      for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
      check(mode == 2'b10, "R2 mode clocked", mode, 2);
      check(drive_en == 1'b1, "R8 drive_en with enable", drive_en, 1);

      // R3/R4: pattern without both-high
      clear_log();
      for (int i = 0; i < 30; i++) send_clocked(i % 3 == 0, i % 3 == 1);
      send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
      compare_log("R3 pattern");
      check(both_err == 1'b0, "R5 no error without both-high", both_err, 0);

      // R3/R4/R5: exhaustive 4-bit words of (p,n) pairs
      clear_log();
      for (int v = 0; v < 256; v++) begin
         for (int b = 0; b < 4; b++) send_clocked(v[2*b], v[2*b+1]);
      end
      send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
      compare_log("R3 sweep");
      check(both_err == 1'b1, "R5 sticky error set", both_err, 1);
      clear_log();
      send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
      check(nlog == 0, "R5 both-high gives no mark", nlog, 0);
      check(both_err == 1'b1, "R5 error stays set", both_err, 1);

      // R9: watchdog boundary, clock stops high
      @(negedge clk); line_clk = 1'b1;
      wait_n(40);
      check(mode == 2'b10, "R9 mode held before idle limit", mode, 2);
      wait_n(50);
      check(mode == 2'b01, "R6 mode clockless", mode, 1);
      check(drive_en == 1'b1, "R6 drive_en in clockless", drive_en, 1);

      // R6: clockless pass-through widths
      clear_log();
      for (int w = 3; w <= 12; w++) begin
         rz_pulse(1'b1, 1'b0, w);
         rz_pulse(1'b0, 1'b1, w);
      end
      rz_pulse(1'b1, 1'b1, 6);
      compare_log("R6 clockless");

      // R7: shut-off, clock held low, data toggling
      @(negedge clk); line_clk = 1'b0;
      wait_n(90);
      clear_log();
      for (int i = 0; i < 25; i++) begin
         @(negedge clk); data_p = i[0]; data_n = i[1];
         wait_n(3);
      end
      data_p = 1'b0; data_n = 1'b0;
      wait_n(10);
      check(mode == 2'b00, "R7 mode shut-off", mode, 0);
      check(drive_en == 1'b0, "R7 drive_en low", drive_en, 0);
      check(nlog == 0, "R7 data ignored", nlog, 0);

      // R8: global enable low with clock running
      tx_enable = 1'b0;
      clear_log();
      for (int i = 0; i < 8; i++) send_bit(i[0], ~i[0]);
      send_bit(1'b0, 1'b0);
      check(mode == 2'b10, "R8 mode clocked while disabled", mode, 2);
      check(drive_en == 1'b0, "R8 drive_en low when disabled", drive_en, 0);
      check(nlog == 0, "R8 no marks when disabled", nlog, 0);
      tx_enable = 1'b1;
      clear_log();
      send_bit(1'b0, 1'b0);
      send_clocked(1'b1, 1'b0); send_clocked(1'b0, 1'b1);
      send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
      check(drive_en == 1'b1, "R8 drive_en after enable", drive_en, 1);
      compare_log("R8 re-enabled");

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule